// File: doc/BRIEF.md
# Floating-Point Status Register and Trap Controller

This block holds the 32-bit status word of a floating-point unit and decides, each time an operation finishes, what that word becomes and whether the integer unit must take a floating-point exception. It sits between the arithmetic datapath and the integer pipeline. From the datapath it takes a completion strobe carrying an exception vector, a compare outcome and a completion status, plus the precision and register numbers of the operands. From the integer pipeline it takes load-status and store-status requests, a store-queue request, the queue-occupancy flag and a trap acknowledge.

The block masks fresh exceptions with the enable field. An enabled exception raises a trap. Masked exceptions are folded into the accumulated field instead. The block also flags misaligned operand registers, bad sequencing and the non-arithmetic completion codes. A trap request is registered and stays up until the integer unit acknowledges it. The trap-type field is sticky: loads leave it alone, and only a store-status request or the next accepted operation clears it.

Top module: `fsr_trap_ctrl`

## Requirements
- R1: The readback word places bits 31:28 as a plain read/write field, the enable mask at 27:23, the non-standard bit at 22, a constant version (parameter, default 5) at 19:17, the trap type at 16:14, the condition codes at 11:10, the accumulated exceptions at 9:5 and the current exceptions at 4:0. Bits 21:20 and 13:12 read zero. After reset every writable field is zero.
- R2: When several trap causes coincide in one cycle, the trap type written follows this priority: hardware error (5), then sequence error (4), then misaligned register (6), then unimplemented (3), then unfinished (2), then IEEE exception (1). Code 0 means no trap.
- R3: Exception vector bits 4..0 are invalid, overflow, underflow, divide-by-zero and inexact. If a normally completing operation has any exception bit set whose enable bit is also set, the block sets the trap type to 1 and raises the trap. The current field takes the vector, and the accumulated field is left unchanged.
- R4: If a normally completing operation has no enabled exception, the accumulated field becomes its old value ORed with the vector, and the trap type becomes 0.
- R5: Every normal completion overwrites the whole current-exception field, so bits that did not occur are cleared.
- R6: An unimplemented completion (status 2) sets trap type 3 and an unfinished one (status 1) sets trap type 2. Both raise the trap and leave the current and accumulated fields unchanged.
- R7: The trap type holds its value through acknowledges and load-status writes. A store-status request clears it, and so does the next accepted operation.
- R8: Precision 1 (double) with any odd register number, or precision 2 (quad) with a register number that is not a multiple of 4, sets trap type 6. Single precision (0) never does.
- R9: A store-queue request while the queue-not-empty flag is 0 sets trap type 4 and raises the trap. With the flag at 1 it has no effect.
- R10: A normal completion flagged as a compare writes its 2-bit result into the condition codes. A load-status write also sets them. The condition-code output always equals the field.
- R11: A completion arriving while a trap is pending and not being acknowledged in that cycle sets trap type 4 and changes no other field.
- R12: The trap request output stays high from the cycle after a trap until the cycle after an acknowledge.
- R13: A hardware-error completion (status 3) sets trap type 5 and raises the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Exception vector of the completing operation |
| op_status | input | 2 | 0 normal, 1 unfinished, 2 unimplemented, 3 hardware error |
| op_cmp | input | 1 | Completing operation is a compare |
| op_fcc | input | 2 | Compare result |
| op_prec | input | 2 | 0 single, 1 double, 2 quad |
| op_regs | input | NUM_OPS*REG_W | Operand register numbers, one REG_W slice each |
| ld_fsr | input | 1 | Load-status write strobe |
| ld_data | input | 32 | Load-status write data |
| st_fsr | input | 1 | Store-status request |
| q_ne | input | 1 | Deferred queue holds entries |
| st_q | input | 1 | Store-queue request |
| trap_ack | input | 1 | Integer unit accepts the trap |
| fsr_rdata | output | 32 | Status word readback |
| fcc_out | output | 2 | Condition codes for branch logic |
| trap_req | output | 1 | Floating-point exception request |

## Verification
The hardest state to reach is a rejected operation. The stimulus raises a trap, loads new field values while the request is still up, and then issues a completion before the acknowledge. The bench can then show that only the trap type moved to the sequence-error code. Coinciding causes form a second hard case, because the datapath never produces them naturally. Dedicated cycles put a hardware error, a misaligned quad operand, an unimplemented status or an empty-queue store in the same cycle, so the priority order becomes visible in the trap type.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    FTT_NONE   = 3'd0,
    FTT_IEEE   = 3'd1,
    FTT_UNFIN  = 3'd2,
    FTT_UNIMP  = 3'd3,
    FTT_SEQ    = 3'd4,
    FTT_HWERR  = 3'd5,
    FTT_BADREG = 3'd6
  } ftt_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_UNFIN = 2'd1,
    ST_UNIMP = 2'd2,
    ST_HWERR = 2'd3
  } opstat_e;

  typedef enum logic [1:0] {
    PR_SINGLE = 2'd0,
    PR_DOUBLE = 2'd1,
    PR_QUAD   = 2'd2
  } prec_e;

  localparam int WORD_W = 32;
  localparam int EXC_W  = 5;
  localparam int FCC_W  = 2;
  localparam int TT_W   = 3;
  localparam int VER_W  = 3;
  localparam int HI_W   = 4;

  localparam int HI_LSB   = 28;
  localparam int TEM_LSB  = 23;
  localparam int NS_BIT   = 22;
  localparam int VER_LSB  = 17;
  localparam int TT_LSB   = 14;
  localparam int FCC_LSB  = 10;
  localparam int AEXC_LSB = 5;
  localparam int CEXC_LSB = 0;

endpackage

// File: rtl/fsr_align_chk.sv
module fsr_align_chk #(
  parameter int NUM_OPS = 3,
  parameter int REG_W   = 5
) (
  input  logic [1:0]               prec,
  input  logic [NUM_OPS*REG_W-1:0] regs,
  output logic                     misalign
);
  import fsr_pkg::*;

  logic [NUM_OPS-1:0] bad;
  logic               unused_hi;

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_opnd
      logic [REG_W-1:0] rnum;
      assign rnum = regs[i*REG_W +: REG_W];
      always_comb begin
        unique case (prec_e'(prec))
          PR_DOUBLE: bad[i] = rnum[0];
          PR_QUAD:   bad[i] = |rnum[1:0];
          default:   bad[i] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign misalign  = |bad;
  assign unused_hi = ^regs;

endmodule

// File: rtl/fsr_trap_prio.sv
module fsr_trap_prio (
  input  logic       hw,
  input  logic       seq,
  input  logic       badreg,
  input  logic       unimp,
  input  logic       unfin,
  input  logic       ieee,
  output logic       fire,
  output logic [2:0] code
);
  import fsr_pkg::*;

  always_comb begin
    fire = 1'b1;
    if (hw)          code = FTT_HWERR;
    else if (seq)    code = FTT_SEQ;
    else if (badreg) code = FTT_BADREG;
    else if (unimp)  code = FTT_UNIMP;
    else if (unfin)  code = FTT_UNFIN;
    else if (ieee)   code = FTT_IEEE;
    else begin
      code = FTT_NONE;
      fire = 1'b0;
    end
  end

endmodule

// File: rtl/fsr_fields.sv
module fsr_fields #(
  parameter logic [2:0] VERSION = 3'd5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_en,
  input  logic [31:0] ld_data,
  input  logic        st_en,
  input  logic        op_accept,
  input  logic        op_upd,
  input  logic [4:0]  op_exc,
  input  logic        op_cmp,
  input  logic [1:0]  op_fcc,
  input  logic        trap_fire,
  input  logic [2:0]  trap_code,
  input  logic        trap_ack,
  output logic        ieee_hit,
  output logic        pend_q,
  output logic [31:0] rdata,
  output logic [1:0]  fcc_q
);
  import fsr_pkg::*;

  logic [HI_W-1:0]  hi_q,   hi_n;
  logic [EXC_W-1:0] tem_q,  tem_n;
  logic             ns_q,   ns_n;
  logic [TT_W-1:0]  ftt_q,  ftt_n;
  logic [FCC_W-1:0] fcc_n;
  logic [EXC_W-1:0] aexc_q, aexc_n;
  logic [EXC_W-1:0] cexc_q, cexc_n;
  logic             pend_n;
  logic             unused_ld;

  assign ieee_hit  = |(tem_q & op_exc);
  assign unused_ld = ^{ld_data[21:17], ld_data[16:14], ld_data[13:12]};

  always_comb begin
    hi_n   = hi_q;
    tem_n  = tem_q;
    ns_n   = ns_q;
    fcc_n  = fcc_q;
    aexc_n = aexc_q;
    cexc_n = cexc_q;
    if (ld_en) begin
      hi_n   = ld_data[HI_LSB +: HI_W];
      tem_n  = ld_data[TEM_LSB +: EXC_W];
      ns_n   = ld_data[NS_BIT];
      fcc_n  = ld_data[FCC_LSB +: FCC_W];
      aexc_n = ld_data[AEXC_LSB +: EXC_W];
      cexc_n = ld_data[CEXC_LSB +: EXC_W];
    end
    if (op_upd) begin
      cexc_n = op_exc;
      if (op_cmp)    fcc_n  = op_fcc;
      if (!ieee_hit) aexc_n = aexc_n | op_exc;
    end
  end

  always_comb begin
    ftt_n = ftt_q;
    if (trap_fire)              ftt_n = trap_code;
    else if (op_accept || st_en) ftt_n = FTT_NONE;
  end

  always_comb begin
    pend_n = pend_q;
    if (trap_fire)     pend_n = 1'b1;
    else if (trap_ack) pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      tem_q  <= '0;
      ns_q   <= 1'b0;
      ftt_q  <= FTT_NONE;
      fcc_q  <= '0;
      aexc_q <= '0;
      cexc_q <= '0;
      pend_q <= 1'b0;
    end else begin
      hi_q   <= hi_n;
      tem_q  <= tem_n;
      ns_q   <= ns_n;
      ftt_q  <= ftt_n;
      fcc_q  <= fcc_n;
      aexc_q <= aexc_n;
      cexc_q <= cexc_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[HI_LSB +: HI_W]     = hi_q;
    rdata[TEM_LSB +: EXC_W]   = tem_q;
    rdata[NS_BIT]             = ns_q;
    rdata[VER_LSB +: VER_W]   = VERSION;
    rdata[TT_LSB +: TT_W]     = ftt_q;
    rdata[FCC_LSB +: FCC_W]   = fcc_q;
    rdata[AEXC_LSB +: EXC_W]  = aexc_q;
    rdata[CEXC_LSB +: EXC_W]  = cexc_q;
  end

  // R12: request persists until acknowledged
  p_trap_hold_r12: assert property (@(posedge clk) disable iff (rst)
    pend_q && !trap_ack |=> pend_q);

  // R7: a load alone never moves the trap type
  p_ld_keeps_ftt_r7: assert property (@(posedge clk) disable iff (rst)
    ld_en && !trap_fire && !op_accept && !st_en |=> $stable(ftt_q));

  // R4: masked exceptions are accumulated
  p_accum_r4: assert property (@(posedge clk) disable iff (rst)
    op_upd && !ieee_hit && !ld_en |=> aexc_q == ($past(aexc_q) | $past(op_exc)));

  // R3: an enabled exception leaves the accumulated field alone
  p_mask_keep_r3: assert property (@(posedge clk) disable iff (rst)
    op_upd && ieee_hit && !ld_en |=> $stable(aexc_q) && pend_q);

  // R6: non-normal completions keep the current field
  p_keep_cexc_r6: assert property (@(posedge clk) disable iff (rst)
    op_accept && !op_upd && !ld_en |=> $stable(cexc_q));

endmodule

// File: rtl/fsr_trap_ctrl.sv
module fsr_trap_ctrl #(
  parameter int         NUM_OPS = 3,
  parameter int         REG_W   = 5,
  parameter logic [2:0] VERSION = 3'd5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_done,
  input  logic [4:0]               op_exc,
  input  logic [1:0]               op_status,
  input  logic                     op_cmp,
  input  logic [1:0]               op_fcc,
  input  logic [1:0]               op_prec,
  input  logic [NUM_OPS*REG_W-1:0] op_regs,
  input  logic                     ld_fsr,
  input  logic [31:0]              ld_data,
  input  logic                     st_fsr,
  input  logic                     q_ne,
  input  logic                     st_q,
  input  logic                     trap_ack,
  output logic [31:0]              fsr_rdata,
  output logic [1:0]               fcc_out,
  output logic                     trap_req
);
  import fsr_pkg::*;

  logic       misalign;
  logic       blocked;
  logic       op_accept;
  logic       op_normal;
  logic       op_upd;
  logic       ieee_hit;
  logic       pend_q;
  logic       trap_fire;
  logic [2:0] trap_code;
  logic       c_hw, c_seq, c_bad, c_unimp, c_unfin, c_ieee;

  fsr_align_chk #(.NUM_OPS(NUM_OPS), .REG_W(REG_W)) i_align (
    .prec     (op_prec),
    .regs     (op_regs),
    .misalign (misalign)
  );

  assign blocked   = pend_q && !trap_ack;
  assign op_accept = op_done && !blocked;
  assign op_normal = opstat_e'(op_status) == ST_OK;
  assign op_upd    = op_accept && op_normal && !misalign;

  assign c_hw    = op_done && opstat_e'(op_status) == ST_HWERR;
  assign c_seq   = (op_done && blocked) || (st_q && !q_ne);
  assign c_bad   = op_accept && misalign;
  assign c_unimp = op_accept && opstat_e'(op_status) == ST_UNIMP;
  assign c_unfin = op_accept && opstat_e'(op_status) == ST_UNFIN;
  assign c_ieee  = op_upd && ieee_hit;

  fsr_trap_prio i_prio (
    .hw     (c_hw),
    .seq    (c_seq),
    .badreg (c_bad),
    .unimp  (c_unimp),
    .unfin  (c_unfin),
    .ieee   (c_ieee),
    .fire   (trap_fire),
    .code   (trap_code)
  );

  fsr_fields #(.VERSION(VERSION)) i_fields (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_fsr),
    .ld_data   (ld_data),
    .st_en     (st_fsr),
    .op_accept (op_accept),
    .op_upd    (op_upd),
    .op_exc    (op_exc),
    .op_cmp    (op_cmp),
    .op_fcc    (op_fcc),
    .trap_fire (trap_fire),
    .trap_code (trap_code),
    .trap_ack  (trap_ack),
    .ieee_hit  (ieee_hit),
    .pend_q    (pend_q),
    .rdata     (fsr_rdata),
    .fcc_q     (fcc_out)
  );

  assign trap_req = pend_q;

  // R9: empty-queue store gives a sequence error
  p_seq_queue_r9: assert property (@(posedge clk) disable iff (rst)
    st_q && !q_ne && !c_hw |=> trap_req && fsr_rdata[16:14] == 3'd4);

  // R8: misaligned operand gives the register code
  p_badreg_r8: assert property (@(posedge clk) disable iff (rst)
    op_done && !blocked && !c_hw && !(st_q && !q_ne) && misalign
      |=> trap_req && fsr_rdata[16:14] == 3'd6);

  // R13: hardware error always wins
  p_hwerr_r13: assert property (@(posedge clk) disable iff (rst)
    c_hw |=> trap_req && fsr_rdata[16:14] == 3'd5);

  // R11: rejected operation touches only the trap type
  p_reject_r11: assert property (@(posedge clk) disable iff (rst)
    op_done && blocked && !c_hw && !ld_fsr
      |=> fsr_rdata[16:14] == 3'd4 && $stable(fsr_rdata[9:0]));

endmodule

// File: tb/test_fsr_trap_ctrl.sv
`timescale 1ns/1ps
module test_fsr_trap_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_done, op_cmp, ld_fsr, st_fsr, q_ne, st_q, trap_ack;
  logic [4:0]  op_exc;
  logic [1:0]  op_status, op_fcc, op_prec;
  logic [14:0] op_regs;
  logic [31:0] ld_data;
  logic [31:0] fsr_rdata;
  logic [1:0]  fcc_out;
  logic        trap_req;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [3:0] e_hi;
  logic [4:0] e_tem, e_aexc, e_cexc;
  logic       e_ns;
  logic [2:0] e_ftt;
  logic [1:0] e_fcc;

  always #2.5 clk = ~clk;

  fsr_trap_ctrl i_fsr_trap_ctrl (
    .clk(clk), .rst(rst), .op_done(op_done), .op_exc(op_exc),
    .op_status(op_status), .op_cmp(op_cmp), .op_fcc(op_fcc),
    .op_prec(op_prec), .op_regs(op_regs), .ld_fsr(ld_fsr),
    .ld_data(ld_data), .st_fsr(st_fsr), .q_ne(q_ne), .st_q(st_q),
    .trap_ack(trap_ack), .fsr_rdata(fsr_rdata), .fcc_out(fcc_out),
    .trap_req(trap_req)
  );

  function automatic logic [31:0] mk(logic [3:0] hi, logic [4:0] tem,
      logic ns, logic [2:0] ftt, logic [1:0] fcc, logic [4:0] ae, logic [4:0] ce);
    logic [31:0] w = '0;
    w[31:28] = hi;  w[27:23] = tem; w[22] = ns; w[19:17] = 3'd5;
    w[16:14] = ftt; w[11:10] = fcc; w[9:5] = ae; w[4:0] = ce;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic exp_trap);
    chk(tag, fsr_rdata, mk(e_hi, e_tem, e_ns, e_ftt, e_fcc, e_aexc, e_cexc));
    chk(tag, {31'd0, trap_req}, {31'd0, exp_trap});
    chk(tag, {30'd0, fcc_out}, {30'd0, e_fcc});
  endtask

  task automatic idle();
    op_done = 0; op_exc = 0; op_status = 0; op_cmp = 0; op_fcc = 0;
    op_prec = 0; op_regs = 0; ld_fsr = 0; ld_data = 0; st_fsr = 0;
    st_q = 0; trap_ack = 0;
  endtask

  task automatic op(logic [4:0] exc, logic [1:0] st, logic [1:0] pr,
                    logic [14:0] regs, logic cmp, logic [1:0] fcc);
    op_done = 1; op_exc = exc; op_status = st; op_prec = pr;
    op_regs = regs; op_cmp = cmp; op_fcc = fcc;
    @(negedge clk);
    idle();
  endtask

  task automatic do_load(logic [3:0] hi, logic [4:0] tem, logic ns,
                         logic [1:0] fcc, logic [4:0] ae, logic [4:0] ce);
    e_hi = hi; e_tem = tem; e_ns = ns; e_fcc = fcc; e_aexc = ae; e_cexc = ce;
    ld_fsr = 1;
    ld_data = mk(hi, tem, ns, 3'd7, fcc, ae, ce) | 32'h0033_3000;
    @(negedge clk);
    idle();
  endtask

  task automatic ack();
    trap_ack = 1;
    @(negedge clk);
    idle();
    chk("R12 ack drops request", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_reset();
    e_hi = 0; e_tem = 0; e_ns = 0; e_ftt = 0; e_fcc = 0; e_aexc = 0; e_cexc = 0;
    chk_all("R1 reset state", 1'b0);
  endtask

  task automatic t_load();
    e_ftt = 0;
    do_load(4'hF, 5'h1F, 1'b1, 2'd3, 5'h1F, 5'h1F);
    chk_all("R1 R10 load all ones", 1'b0);
    do_load(0, 0, 0, 0, 0, 0);
    chk_all("R1 load zeros", 1'b0);
  endtask

  task automatic t_accum();
    op(5'b00101, 2'd0, 2'd0, 15'd0, 0, 0);
    e_cexc = 5'b00101; e_aexc = 5'b00101; e_ftt = 0;
    chk_all("R4 masked accumulate", 1'b0);
    op(5'b10000, 2'd0, 2'd0, 15'd0, 0, 0);
    e_cexc = 5'b10000; e_aexc = 5'b10101;
    chk_all("R5 R4 current rewritten", 1'b0);
  endtask

  task automatic t_mask();
    do_load(0, 5'b01000, 0, 0, 0, 0);
    op(5'b01001, 2'd0, 2'd0, 15'd0, 0, 0);
    e_cexc = 5'b01001; e_ftt = 3'd1;
    chk_all("R3 enabled trap", 1'b1);
    repeat (3) @(negedge clk);
    chk_all("R12 request held", 1'b1);
    do_load(0, 5'b01000, 0, 0, 5'b00011, 0);
    chk_all("R7 load ignores trap type", 1'b1);
    op(5'b00001, 2'd0, 2'd0, 15'd0, 0, 0);
    e_ftt = 3'd4;
    chk_all("R11 op while pending", 1'b1);
    ack();
    chk_all("R7 sticky after ack", 1'b0);
    st_fsr = 1; @(negedge clk); idle();
    e_ftt = 0;
    chk_all("R7 store clears", 1'b0);
  endtask

  task automatic t_next_op();
    op(5'b01000, 2'd0, 2'd0, 15'd0, 0, 0);
    e_cexc = 5'b01000; e_ftt = 3'd1;
    chk_all("R3 second trap", 1'b1);
    ack();
    op(5'b00000, 2'd0, 2'd0, 15'd0, 0, 0);
    e_cexc = 0; e_ftt = 0;
    chk_all("R7 R5 next op clears", 1'b0);
  endtask

  task automatic t_unimpl();
    op(5'b00010, 2'd0, 2'd0, 15'd0, 0, 0);
    e_cexc = 5'b00010; e_aexc = 5'b00011;
    chk_all("R4 inexact-free accumulate", 1'b0);
    op(5'b11111, 2'd2, 2'd0, 15'd0, 0, 0);
    e_ftt = 3'd3;
    chk_all("R6 unimplemented", 1'b1);
    ack();
    op(5'b11111, 2'd1, 2'd0, 15'd0, 0, 0);
    e_ftt = 3'd2;
    chk_all("R6 unfinished", 1'b1);
    ack();
  endtask

  task automatic t_align();
    op(0, 2'd0, 2'd1, {5'd0, 5'd0, 5'd3}, 0, 0);
    e_ftt = 3'd6;
    chk_all("R8 double odd", 1'b1);
    ack();
    op(0, 2'd0, 2'd2, {5'd6, 5'd0, 5'd0}, 0, 0);
    chk_all("R8 quad not 4-aligned", 1'b1);
    ack();
    op(0, 2'd0, 2'd2, {5'd12, 5'd8, 5'd4}, 0, 0);
    e_ftt = 0; e_cexc = 0;
    chk_all("R8 quad aligned", 1'b0);
    op(0, 2'd0, 2'd0, {5'd3, 5'd5, 5'd7}, 0, 0);
    chk_all("R8 single odd ok", 1'b0);
  endtask

  task automatic t_queue();
    q_ne = 0; st_q = 1; @(negedge clk); idle();
    e_ftt = 3'd4;
    chk_all("R9 empty queue store", 1'b1);
    ack();
    st_fsr = 1; @(negedge clk); idle();
    e_ftt = 0;
    q_ne = 1; st_q = 1; @(negedge clk); idle();
    chk_all("R9 non-empty queue store", 1'b0);
  endtask

  task automatic t_prio();
    op(0, 2'd3, 2'd0, 15'd0, 0, 0);
    e_ftt = 3'd5;
    chk_all("R13 hardware error", 1'b1);
    ack();
    op(0, 2'd3, 2'd1, 15'd1, 0, 0);
    chk_all("R2 hw over misalign", 1'b1);
    ack();
    op(0, 2'd2, 2'd2, 15'd2, 0, 0);
    e_ftt = 3'd6;
    chk_all("R2 misalign over unimpl", 1'b1);
    ack();
    op(5'b01000, 2'd0, 2'd1, 15'd1, 0, 0);
    chk_all("R2 misalign over ieee", 1'b1);
    ack();
    q_ne = 0; st_q = 1;
    op(0, 2'd2, 2'd0, 15'd0, 0, 0);
    q_ne = 1;
    e_ftt = 3'd4;
    chk_all("R2 sequence over unimpl", 1'b1);
    ack();
  endtask

  task automatic t_cmp();
    op(0, 2'd0, 2'd0, 15'd0, 1, 2'd2);
    e_fcc = 2'd2; e_ftt = 0; e_cexc = 0;
    chk_all("R10 compare sets codes", 1'b0);
    do_load(4'h9, 5'b01000, 0, 2'd1, 5'b00011, 0);
    chk_all("R10 R1 load codes", 1'b0);
  endtask

  initial begin
    idle(); q_ne = 1; rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_load();
    t_accum();
    t_mask();
    t_next_op();
    t_unimpl();
    t_align();
    t_queue();
    t_prio();
    t_cmp();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule